// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer

This block is a synchronous controller for a one-bit-wide asynchronous DRAM. The row and column addresses share one set of pins, and the block drives the active-low row strobe, column strobe and write enable. A host presents one request at a time. Each request carries a 24-bit address, a write flag, one data bit and a keep-open flag. The controller activates the row, runs a column access, and returns read data with a one-cycle valid pulse. When the keep-open flag is set, the row stays open so that later requests to the same row need only a column cycle.

Every DRAM timing limit is a nanosecond parameter. The block turns each one into whole clock cycles, rounding up, from a clock-period parameter. An external arbiter, for example a refresh scheduler, takes the pins away by lowering a grant input. While grant is low the controller starts no activation and closes any open row. Writes use early-write timing: write enable is already low when the column strobe falls.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset the row strobe, column strobe and write enable are high, rd_valid_o is low, and busy_o is low while gnt_i is high.
- R2: The row address, req_addr_i[23:12], is on dram_addr_o when the row strobe falls. The column address, req_addr_i[11:0], is on dram_addr_o and stable in the cycle before the column strobe falls.
- R3: A write drives write enable low before the column strobe falls and keeps it low while the strobe is low. The bit on dram_din_o is the bit stored.
- R4: A read returns the stored bit on rd_data_o with rd_valid_o high for exactly one cycle, after the column strobe has been low for the longest access time.
- R5: The row strobe stays high for at least tRP between activations. The row strobe's high time plus its preceding low time is at least tRC. Each low phase of the row strobe lasts at least tRAS.
- R6: The row-to-column strobe delay is at least tRCD. The column strobe is low only while the row strobe is low, and each low phase lasts at least tCAS. Within a page, the column strobe is high for at least tCP and a full column cycle is at least tPC.
- R7: After an access with the keep-open flag set, a request to the same row is served without a new row activation.
- R8: A request to a different row while a page is open raises the row strobe, waits out the precharge and then activates the new row.
- R9: The row strobe never stays low longer than tRASP. An open page with no traffic is closed by the page timer.
- R10: Requests are not taken while busy_o is high. An activation starts only in the cycle after req_valid_i was high with busy_o low.
- R11: With gnt_i low no activation starts, busy_o is high and an open page is closed. Service resumes when gnt_i returns high.
- R12: An access without the keep-open flag closes its row as soon as tRAS allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present, held until taken |
| req_addr_i | input | 24 | Row in bits 23:12, column in bits 11:0 |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 1 | Write data bit |
| req_burst_i | input | 1 | Keep the row open after this access |
| gnt_i | input | 1 | Pin ownership grant from the arbiter |
| busy_o | output | 1 | Request cannot be taken this cycle |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 1 | Read data bit |
| dram_addr_o | output | 12 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_din_o | output | 1 | Data to the DRAM |
| dram_dout_i | input | 1 | Data from the DRAM |

## Verification
The main function is driven from a table that mixes the following cases:
- writes then reads in the same row with the keep-open flag set, which separates page hits from new activations;
- a switch to a different row while a page is open, which exercises the forced close and precharge;
- accesses at all-ones and all-zeros addresses, which show that the row and column fields are split correctly;
- a read of a never-written cell, which shows that stale read data is not reused.

A behavioural DRAM model in the bench stores the bits, and strobe-width monitors measure every low and high phase against the nanosecond limits. Directed cases then hold a page idle until the timer closes it and withdraw the grant with a page open and a request pending.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_OPEN = 3'd3,
    ST_CADR = 3'd4,
    ST_PRE  = 3'd5
  } fpm_state_e;

  function automatic int ns_to_cyc(input int ns, input int per_ps);
    return (ns * 1000 + per_ps - 1) / per_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_dram_pkg::*;
#(
  parameter int ADR_W = 12,
  parameter int RAH_C = 2,
  parameter int RCD_C = 4,
  parameter int CAS_C = 8,
  parameter int CP_C  = 2,
  parameter int PRE_C = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ADR_W-1:0] req_row_i,
  input  logic [ADR_W-1:0] req_col_i,
  input  logic             req_we_i,
  input  logic             req_wdata_i,
  input  logic             req_burst_i,
  input  logic             gnt_i,
  input  logic             ras_min_ok_i,
  input  logic             page_full_i,
  output logic             busy_o,
  output fpm_state_e       state_o,
  output logic [ADR_W-1:0] row_o,
  output logic [ADR_W-1:0] col_o,
  output logic             we_o,
  output logic             wdata_o,
  output logic             col_phase_o,
  output logic             rd_strobe_o
);
  localparam int CNT_MAX = imax(imax(RCD_C, CAS_C), imax(CP_C, PRE_C));
  localparam int CW      = $clog2(CNT_MAX + 1);

  fpm_state_e       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [ADR_W-1:0] row_q, col_q;
  logic             we_q, wd_q, burst_q;
  logic             row_hit, take_idle, take_open, acc, close_now;

  always_comb begin
    row_hit   = (req_row_i == row_q);
    take_idle = (st_q == ST_IDLE) && gnt_i;
    take_open = (st_q == ST_OPEN) && burst_q && row_hit && gnt_i && !page_full_i;
    busy_o    = !(take_idle || take_open);
    acc       = req_valid_i && !busy_o;
    // page closes on: single access, timer, lost grant, row miss
    close_now = (st_q == ST_OPEN) && ras_min_ok_i &&
                (!burst_q || page_full_i || !gnt_i || (req_valid_i && !row_hit));
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (acc) st_d = ST_ROW;
      end
      ST_ROW: if (cnt_q == CW'(RCD_C - 1)) begin
        st_d  = ST_COL;
        cnt_d = '0;
      end
      ST_COL: if (cnt_q == CW'(CAS_C - 1)) begin
        st_d  = ST_OPEN;
        cnt_d = '0;
      end
      ST_OPEN: begin
        cnt_d = '0;
        if (acc)            st_d = ST_CADR;
        else if (close_now) st_d = ST_PRE;
      end
      ST_CADR: if (cnt_q == CW'(CP_C - 1)) begin
        st_d  = ST_COL;
        cnt_d = '0;
      end
      ST_PRE: if (cnt_q == CW'(PRE_C - 1)) begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
      we_q    <= 1'b0;
      wd_q    <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (acc) begin
        if (st_q == ST_IDLE) row_q <= req_row_i;
        col_q   <= req_col_i;
        we_q    <= req_we_i;
        wd_q    <= req_wdata_i;
        burst_q <= req_burst_i;
      end
    end
  end

  assign state_o     = st_q;
  assign row_o       = row_q;
  assign col_o       = col_q;
  assign we_o        = we_q;
  assign wdata_o     = wd_q;
  assign col_phase_o = !((st_q == ST_ROW) && (cnt_q < CW'(RAH_C)));
  assign rd_strobe_o = (st_q == ST_COL) && (cnt_q == CW'(CAS_C - 1)) && !we_q;

endmodule

// File: rtl/fpm_page_timer.sv
module fpm_page_timer #(
  parameter int RASMIN_C = 12,
  parameter int PAGE_LIM = 19988,
  parameter int RASP_C   = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_low_i,
  output logic min_ok_o,
  output logic full_o
);
  localparam int TW = $clog2(RASP_C + 2);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!ras_low_i)              cnt_q <= '0;
    else if (cnt_q != {TW{1'b1}})     cnt_q <= cnt_q + 1'b1;
  end

  // cnt_q counts low cycles already elapsed; closing adds the current one
  assign min_ok_o = cnt_q >= TW'(RASMIN_C - 1);
  assign full_o   = cnt_q >= TW'(PAGE_LIM);

endmodule

// File: rtl/fpm_pin_drv.sv
module fpm_pin_drv
  import fpm_dram_pkg::*;
#(
  parameter int ADR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fpm_state_e       state_i,
  input  logic [ADR_W-1:0] row_i,
  input  logic [ADR_W-1:0] col_i,
  input  logic             we_i,
  input  logic             wdata_i,
  input  logic             col_phase_i,
  input  logic             rd_strobe_i,
  input  logic             dram_dout_i,
  output logic [ADR_W-1:0] dram_addr_o,
  output logic             dram_ras_no,
  output logic             dram_cas_no,
  output logic             dram_we_no,
  output logic             dram_din_o,
  output logic             rd_valid_o,
  output logic             rd_data_o
);
  logic wr_win;

  always_comb begin
    dram_ras_no = (state_i == ST_IDLE) || (state_i == ST_PRE);
    dram_cas_no = (state_i != ST_COL);
    wr_win      = (state_i == ST_ROW) || (state_i == ST_CADR) || (state_i == ST_COL);
    dram_we_no  = !(we_i && wr_win);
    dram_din_o  = we_i & wdata_i;
    dram_addr_o = col_phase_i ? col_i : row_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= 1'b0;
    end else begin
      rd_valid_o <= rd_strobe_i;
      if (rd_strobe_i) rd_data_o <= dram_dout_i;
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_dram_pkg::*;
#(
  parameter int ADR_W         = 12,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_RP_NS       = 40,
  parameter int T_RC_NS       = 110,
  parameter int T_RAS_NS      = 60,
  parameter int T_RASP_NS     = 100000,
  parameter int T_RCD_NS      = 20,
  parameter int T_RAH_NS      = 10,
  parameter int T_CAS_NS      = 15,
  parameter int T_CP_NS       = 10,
  parameter int T_PC_NS       = 40,
  parameter int T_RAC_NS      = 60,
  parameter int T_CAC_NS      = 15,
  parameter int T_AA_NS       = 30,
  parameter int T_CPA_NS      = 35
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [2*ADR_W-1:0] req_addr_i,
  input  logic               req_we_i,
  input  logic               req_wdata_i,
  input  logic               req_burst_i,
  input  logic               gnt_i,
  output logic               busy_o,
  output logic               rd_valid_o,
  output logic               rd_data_o,
  output logic [ADR_W-1:0]   dram_addr_o,
  output logic               dram_ras_no,
  output logic               dram_cas_no,
  output logic               dram_we_no,
  output logic               dram_din_o,
  input  logic               dram_dout_i
);
  localparam int P        = CLK_PERIOD_PS;
  localparam int RAH_C    = ns_to_cyc(T_RAH_NS, P);
  localparam int RCD_C    = imax(ns_to_cyc(T_RCD_NS, P), RAH_C + 1);
  localparam int CP_C     = ns_to_cyc(T_CP_NS, P);
  localparam int AA_C     = ns_to_cyc(T_AA_NS, P);
  // CAS low long enough for every access path and for the page cycle
  localparam int CAS_C    = imax(imax(imax(ns_to_cyc(T_CAS_NS, P), ns_to_cyc(T_CAC_NS, P)),
                                      imax(ns_to_cyc(T_RAC_NS, P) - RCD_C, AA_C - (RCD_C - RAH_C))),
                                 imax(imax(AA_C - CP_C, ns_to_cyc(T_CPA_NS, P) - CP_C),
                                      ns_to_cyc(T_PC_NS, P) - CP_C - 1));
  localparam int RASMIN_C = ns_to_cyc(T_RAS_NS, P);
  localparam int PRE_C    = imax(ns_to_cyc(T_RP_NS, P), ns_to_cyc(T_RC_NS, P) - RASMIN_C);
  localparam int RASP_C   = ns_to_cyc(T_RASP_NS, P);
  localparam int PAGE_LIM = RASP_C - CP_C - CAS_C - 2;

  fpm_state_e       state;
  logic [ADR_W-1:0] row, col;
  logic             we, wdata, col_phase, rd_strobe, ras_min_ok, page_full;

  fpm_seq #(
    .ADR_W(ADR_W), .RAH_C(RAH_C), .RCD_C(RCD_C),
    .CAS_C(CAS_C), .CP_C(CP_C), .PRE_C(PRE_C)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_row_i    (req_addr_i[2*ADR_W-1:ADR_W]),
    .req_col_i    (req_addr_i[ADR_W-1:0]),
    .req_we_i     (req_we_i),
    .req_wdata_i  (req_wdata_i),
    .req_burst_i  (req_burst_i),
    .gnt_i        (gnt_i),
    .ras_min_ok_i (ras_min_ok),
    .page_full_i  (page_full),
    .busy_o       (busy_o),
    .state_o      (state),
    .row_o        (row),
    .col_o        (col),
    .we_o         (we),
    .wdata_o      (wdata),
    .col_phase_o  (col_phase),
    .rd_strobe_o  (rd_strobe)
  );

  fpm_page_timer #(
    .RASMIN_C(RASMIN_C), .PAGE_LIM(PAGE_LIM), .RASP_C(RASP_C)
  ) i_page_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ras_low_i (!dram_ras_no),
    .min_ok_o  (ras_min_ok),
    .full_o    (page_full)
  );

  fpm_pin_drv #(
    .ADR_W(ADR_W)
  ) i_pin_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .row_i       (row),
    .col_i       (col),
    .we_i        (we),
    .wdata_i     (wdata),
    .col_phase_i (col_phase),
    .rd_strobe_i (rd_strobe),
    .dram_dout_i (dram_dout_i),
    .dram_addr_o (dram_addr_o),
    .dram_ras_no (dram_ras_no),
    .dram_cas_no (dram_cas_no),
    .dram_we_no  (dram_we_no),
    .dram_din_o  (dram_din_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk
  import fpm_dram_pkg::*;
#(
  parameter int ADR_W         = 12,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_RP_NS       = 40,
  parameter int T_RASP_NS     = 100000,
  parameter int T_RCD_NS      = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             gnt_i,
  input logic             busy_o,
  input logic             rd_valid_o,
  input logic [ADR_W-1:0] dram_addr_o,
  input logic             dram_ras_no,
  input logic             dram_cas_no,
  input logic             dram_we_no
);
  localparam int RP_C   = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int RASP_C = ns_to_cyc(T_RASP_NS, CLK_PERIOD_PS);
  localparam int RCD_C  = ns_to_cyc(T_RCD_NS, CLK_PERIOD_PS);

  logic [31:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= 32'(RP_C);
      lo_cnt <= '0;
    end else begin
      hi_cnt <= dram_ras_no ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1) : '0;
      lo_cnt <= dram_ras_no ? '0 : lo_cnt + 1;
    end
  end

  AST_RP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> hi_cnt >= 32'(RP_C)); // R5
  AST_RASP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_ras_no |-> lo_cnt < 32'(RASP_C)); // R9
  AST_RCD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> lo_cnt >= 32'(RCD_C)); // R6
  AST_CAS_IN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no); // R6
  AST_COL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> $stable(dram_addr_o) && $stable(dram_we_no)); // R2
  AST_ACT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> $past(req_valid_i && !busy_o && gnt_i)); // R10
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R4

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .ADR_W(ADR_W), .CLK_PERIOD_PS(CLK_PERIOD_PS), .T_RP_NS(T_RP_NS),
  .T_RASP_NS(T_RASP_NS), .T_RCD_NS(T_RCD_NS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .gnt_i       (gnt_i),
  .busy_o      (busy_o),
  .rd_valid_o  (rd_valid_o),
  .dram_addr_o (dram_addr_o),
  .dram_ras_no (dram_ras_no),
  .dram_cas_no (dram_cas_no),
  .dram_we_no  (dram_we_no)
);

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;
  // limits in 5 ns cycles, rounded up from the ns figures
  localparam int RP_CY = 8, RC_CY = 22, RAS_CY = 12, RASP_CY = 120;
  localparam int RCD_CY = 4, CAS_CY = 3, CP_CY = 2, PC_CY = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_we = 0, req_wdata = 0, req_burst = 0, gnt = 1;
  logic [23:0] req_addr = '0;
  logic busy, rd_valid, rd_data, ras_n, cas_n, we_n, din;
  logic [11:0] addr;
  logic dout_m = 1'b0;

  always #2.5 clk = ~clk;

  fpm_dram_ctrl #(.T_RASP_NS(600)) i_fpm_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_wdata_i(req_wdata), .req_burst_i(req_burst), .gnt_i(gnt),
    .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .dram_addr_o(addr),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_din_o(din),
    .dram_dout_i(dout_m)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int viol5 = 0, viol6 = 0, viol9 = 0, act_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // DRAM model and strobe monitor, sampled mid-cycle
  bit mem [logic [23:0]];
  logic [11:0] row_m = '0, last_row = '0, last_col = '0;
  logic last_we = 1'b1;
  logic ras_p = 1'b1, cas_p = 1'b1;
  int hi_len = 100, lo_len = 0, last_lo = 100, cas_lo = 0, cas_hi = 100;
  bit first_cas = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ras_p = 1'b1; cas_p = 1'b1;
    end else begin
      if (!ras_n) begin
        if (ras_p) begin
          if (hi_len < RP_CY || hi_len + last_lo < RC_CY) viol5++;
          act_cnt++; row_m = addr; last_row = addr; lo_len = 1; first_cas = 1;
        end else lo_len++;
        if (lo_len > RASP_CY) viol9++;
      end else begin
        if (!ras_p) begin
          if (lo_len < RAS_CY) viol5++;
          last_lo = lo_len; hi_len = 1;
        end else hi_len++;
      end
      if (!cas_n) begin
        if (ras_n) viol6++;
        if (cas_p) begin
          if (first_cas) begin
            if (lo_len - 1 < RCD_CY) viol6++;
          end else if (cas_hi < CP_CY || cas_hi + cas_lo < PC_CY) viol6++;
          first_cas = 0;
          last_col = addr; last_we = we_n;
          if (!we_n) mem[{row_m, addr}] = din;
          else dout_m = mem.exists({row_m, addr}) ? mem[{row_m, addr}] : 1'b0;
          cas_lo = 1;
        end else cas_lo++;
      end else begin
        if (!cas_p) begin
          if (cas_lo < CAS_CY) viol6++;
          cas_hi = 1;
        end else cas_hi++;
      end
      ras_p = ras_n; cas_p = cas_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_req(input bit we, input logic [23:0] a, input bit d, input bit burst,
                        output bit rd);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_burst = burst;
    #0.1;
    while (busy) begin @(negedge clk); #0.1; end
    @(negedge clk);
    req_valid = 0;
    rd = 0;
    if (!we) begin
      while (!rd_valid) @(negedge clk);
      rd = rd_data;
    end
  endtask

  // {we, addr, wdata, burst, expected read}
  localparam logic [27:0] VEC [11] = '{
    {1'b1, 24'h123045, 1'b1, 1'b1, 1'b0},
    {1'b1, 24'h123046, 1'b0, 1'b1, 1'b0},
    {1'b1, 24'h123047, 1'b1, 1'b1, 1'b0},
    {1'b1, 24'h456045, 1'b1, 1'b0, 1'b0},
    {1'b0, 24'h123045, 1'b0, 1'b1, 1'b1},
    {1'b0, 24'h123046, 1'b0, 1'b1, 1'b0},
    {1'b0, 24'h123047, 1'b0, 1'b1, 1'b1},
    {1'b0, 24'h456045, 1'b0, 1'b0, 1'b1},
    {1'b1, 24'hFFFFFF, 1'b1, 1'b0, 1'b0},
    {1'b0, 24'hFFFFFF, 1'b0, 1'b0, 1'b1},
    {1'b0, 24'h000000, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    bit rd;
    int act0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n == 1, "R1 ras", ras_n, 1);
    chk(cas_n == 1, "R1 cas", cas_n, 1);
    chk(we_n == 1, "R1 we", we_n, 1);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);

    for (int i = 0; i < 11; i++) begin
      logic [27:0] v;
      v = VEC[i];
      act0 = act_cnt;
      do_req(v[27], v[26:3], v[2], v[1], rd);
      repeat (20) @(negedge clk);
      chk(last_row == v[26:15], "R2 row", int'(last_row), int'(v[26:15]));
      chk(last_col == v[14:3], "R2 col", int'(last_col), int'(v[14:3]));
      if (v[27]) chk(last_we == 0, "R3 we at cas", last_we, 0);
      else chk(rd == v[0], "R4 read", rd, v[0]);
      if (i == 3) chk(act_cnt - act0 == 1, "R8 new row", act_cnt - act0, 1);
      if (i == 5 || i == 6) chk(act_cnt == act0, "R7 page hit", act_cnt - act0, 0);
    end

    // R12 single access closes row
    repeat (10) @(negedge clk);
    chk(ras_n == 1, "R12 closed", ras_n, 1);

    // R7 page burst over three columns
    act0 = act_cnt;
    do_req(1'b0, 24'h123045, 1'b0, 1'b1, rd);
    chk(rd == 1, "R7 rd0", rd, 1);
    do_req(1'b0, 24'h123046, 1'b0, 1'b1, rd);
    chk(rd == 0, "R7 rd1", rd, 0);
    do_req(1'b0, 24'h123047, 1'b0, 1'b0, rd);
    chk(rd == 1, "R7 rd2", rd, 1);
    chk(act_cnt - act0 == 1, "R7 one activation", act_cnt - act0, 1);

    // R9 idle page closed by timer
    do_req(1'b0, 24'h456045, 1'b0, 1'b1, rd);
    repeat (200) @(negedge clk);
    chk(ras_n == 1, "R9 timer close", ras_n, 1);

    // R11 grant withdrawn with page open and request pending
    do_req(1'b0, 24'h456045, 1'b0, 1'b1, rd);
    repeat (3) @(negedge clk);
    gnt = 0;
    repeat (40) @(negedge clk);
    chk(ras_n == 1, "R11 page closed", ras_n, 1);
    chk(busy == 1, "R10 busy without grant", busy, 1);
    act0 = act_cnt;
    req_valid = 1; req_we = 0; req_addr = 24'hFFFFFF; req_burst = 0;
    repeat (50) @(negedge clk);
    chk(act_cnt == act0, "R11 no activation", act_cnt - act0, 0);
    chk(ras_n == 1, "R10 request held off", ras_n, 1);
    req_valid = 0;
    gnt = 1;
    do_req(1'b0, 24'hFFFFFF, 1'b0, 1'b0, rd);
    chk(rd == 1, "R11 resume", rd, 1);
    repeat (40) @(negedge clk);

    chk(viol5 == 0, "R5 precharge/cycle", viol5, 0);
    chk(viol6 == 0, "R6 cas timing", viol6, 0);
    chk(viol9 == 0, "R9 max ras low", viol9, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule